// File: doc/BRIEF.md
# Four-Pin Voltage ID Sender

This block tells an external core-voltage regulator which output level to produce. The 6-bit voltage code travels over four pins: a select line and a 3-bit data bus. The two halves of the code take turns on the bus. While select is low the bus carries the lower three bits, and while select is high it carries the upper three bits. Select toggles continuously once a code has been loaded.

Each phase lasts a programmable number of reference-clock cycles. A zero length selects a built-in default: the smallest cycle count that covers 70 µs at the configured reference frequency, which is 2100 cycles at 30 MHz. Select and bus are registered outputs that change at the same clock edge, so the bus settles within one register delay of the select edge. That is far inside the 300 ns the regulator allows.

A code offered with the load strobe while the pins are already cycling is held back. It takes effect at the start of the next select-low phase, so the regulator never pairs a lower half of one code with an upper half of another.

FSM states:
- IDLE: pins quiet, waiting for the first code.
- LOW: lower half on the bus.
- HIGH: upper half on the bus.

Transitions:
- IDLE→LOW on a load.
- LOW→HIGH when the phase counter expires.
- HIGH→LOW when the phase counter expires, committing any held code.

Top module: `vid_pin_sender`

## Requirements
- R1: After reset, select is low and the bus is zero. Both stay that way, whatever the other inputs do, until the first load strobe.
- R2: During a select-low phase, the bus equals bits [2:0] of the code in force.
- R3: During a select-high phase, the bus equals bits [5:3] of the code in force.
- R4: At every phase change, select and bus take their new values at the same clock edge. There is no cycle in which select has moved but the bus still shows the old half.
- R5: Each phase lasts exactly N cycles, where N is the hold-length input sampled at the edge that starts the phase. A change to that input during a phase affects only later phases.
- R6: A hold length of zero selects the default of ceil(REF_KHZ*70/1000) cycles, which is 2100 at the default 30000 kHz.
- R7: In the idle state, a load strobe sampled at an edge starts a select-low phase at that same edge, showing the new code's lower half.
- R8: A code loaded while the pins are cycling does not change the bus until the next select-low phase begins. The upper half of the current code is still sent unchanged.
- R9: If several loads arrive before a select-low phase begins, the last one is used. This includes a load sampled at the very edge that begins the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| vid_in | input | CODE_W (6) | Voltage code to send |
| vid_load | input | 1 | One-cycle strobe that captures vid_in |
| hold_len | input | CNT_W (16) | Phase length in cycles; zero selects the default |
| vid_sel | output | 1 | Select line; low = lower half, high = upper half |
| vid_bus | output | CODE_W/2 (3) | Data half currently presented |

## Verification
Every output change falls a fixed number of edges after its cause:
- A load in idle shows up at the very edge that samples it.
- Each later change comes exactly N edges after the previous one, with N taken at the phase start.

A reference model in the bench runs at each rising edge and works out the cycle and pin values of each expected change, then queues them. A monitor samples at the falling edge, so it sees settled register outputs. It pairs every observed change with the head of the queue and requires the cycle number to match exactly. Any change that is not expected, or any expected change that is missing, is reported. Long default-length phases are checked the same way, cycle for cycle.

// File: rtl/vid_pkg.sv
package vid_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } vid_phase_e;

    // Smallest cycle count covering hold_us at a clock of ref_khz.
    function automatic int hold_cycles_for(input int ref_khz, input int hold_us);
        return (ref_khz * hold_us + 999) / 1000;
    endfunction

endpackage

// File: rtl/vid_hold_timer.sv
module vid_hold_timer #(
    parameter int CNT_W    = 16,
    parameter int DEF_HOLD = 2100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len_in,
    output logic             done
);
    localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(DEF_HOLD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_len;

    // zero length falls back to the built-in minimum hold
    assign eff_len = (len_in == '0) ? DEF_LEN : len_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= eff_len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/vid_code_stage.sv
module vid_code_stage #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              commit,
    output logic [CODE_W-1:0] nxt_code,
    output logic [CODE_W-1:0] act_code
);
    logic [CODE_W-1:0] pend_q;
    logic              pend_vld_q;
    logic [CODE_W-1:0] act_q;

    // newest code wins, including one arriving on the commit edge itself
    always_comb begin
        if (load)
            nxt_code = code_in;
        else if (pend_vld_q)
            nxt_code = pend_q;
        else
            nxt_code = act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            act_q      <= '0;
        end else if (commit) begin
            act_q      <= nxt_code;
            pend_vld_q <= 1'b0;
        end else if (load) begin
            pend_q     <= code_in;
            pend_vld_q <= 1'b1;
        end
    end

    assign act_code = act_q;

endmodule

// File: rtl/vid_pin_sender.sv
module vid_pin_sender #(
    parameter int CODE_W      = 6,
    parameter int CNT_W       = 16,
    parameter int REF_KHZ     = 30000,
    parameter int MIN_HOLD_US = 70
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CODE_W-1:0]     vid_in,
    input  logic                  vid_load,
    input  logic [CNT_W-1:0]      hold_len,
    output logic                  vid_sel,
    output logic [CODE_W/2-1:0]   vid_bus
);
    import vid_pkg::*;

    localparam int HALF_W   = CODE_W / 2;
    localparam int DEF_HOLD = hold_cycles_for(REF_KHZ, MIN_HOLD_US);

    vid_phase_e        state_q, state_d;
    logic              tmr_done;
    logic              enter_low, enter_high;
    logic [CODE_W-1:0] nxt_code, act_code;

    assign enter_low  = ((state_q == PH_IDLE) && vid_load) ||
                        ((state_q == PH_HIGH) && tmr_done);
    assign enter_high = (state_q == PH_LOW) && tmr_done;

    vid_hold_timer #(
        .CNT_W    (CNT_W),
        .DEF_HOLD (DEF_HOLD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (enter_low | enter_high),
        .len_in (hold_len),
        .done   (tmr_done)
    );

    vid_code_stage #(
        .CODE_W (CODE_W)
    ) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (vid_load),
        .code_in  (vid_in),
        .commit   (enter_low),
        .nxt_code (nxt_code),
        .act_code (act_code)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (vid_load) state_d = PH_LOW;
            PH_LOW:  if (tmr_done) state_d = PH_HIGH;
            PH_HIGH: if (tmr_done) state_d = PH_LOW;
            default: state_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // pin register: select and bus move on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_sel <= 1'b0;
            vid_bus <= '0;
        end else if (enter_low) begin
            vid_sel <= 1'b0;
            vid_bus <= nxt_code[HALF_W-1:0];
        end else if (enter_high) begin
            vid_sel <= 1'b1;
            vid_bus <= act_code[CODE_W-1:HALF_W];
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) |-> (!vid_sel && (vid_bus == '0)))
        else $error("idle_quiet_chk");

    // R2
    low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW) |-> (!vid_sel && (vid_bus == act_code[HALF_W-1:0])))
        else $error("low_half_chk");

    // R3
    high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH) |-> (vid_sel && (vid_bus == act_code[CODE_W-1:HALF_W])))
        else $error("high_half_chk");

    // R4
    sel_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != PH_IDLE) && tmr_done) |=> (vid_sel != $past(vid_sel)))
        else $error("sel_toggle_chk");

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != PH_IDLE) && !tmr_done) |=> ($stable(vid_sel) && $stable(vid_bus)))
        else $error("phase_hold_chk");

    // R8
    code_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != PH_IDLE) && !enter_low) |=> $stable(act_code))
        else $error("code_freeze_chk");

endmodule

// File: tb/sim_vid_pin_sender.sv
`timescale 1ns/1ps
module sim_vid_pin_sender;
    localparam int CLK_PERIOD = 10;
    localparam int DEF_HOLD   = 2100;

    typedef struct {
        logic       s;
        logic [2:0] b;
        int         c;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  vid_in = '0;
    logic        vid_load = 1'b0;
    logic [15:0] hold_len = 16'd4;
    logic        vid_sel;
    logic [2:0]  vid_bus;

    exp_t  q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R7";

    // reference model state
    bit         m_on = 0;
    bit         m_sel = 0;
    logic [5:0] m_act = '0;
    logic [5:0] m_pend = '0;
    bit         m_pv = 0;
    int         m_end = 0;
    logic [3:0] m_prev = '0;

    vid_pin_sender u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_in   (vid_in),
        .vid_load (vid_load),
        .hold_len (hold_len),
        .vid_sel  (vid_sel),
        .vid_bus  (vid_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic int eff_len(input logic [15:0] h);
        return (h == 16'd0) ? DEF_HOLD : int'(h);
    endfunction

    task automatic push_exp(input logic s, input logic [2:0] b, input int c, input string base);
        exp_t e;
        if ({s, b} != m_prev) begin
            e.s = s; e.b = b; e.c = c; e.req = {base, " ", cur_req};
            q.push_back(e);
        end
        m_prev = {s, b};
    endtask

    // driver side: requirement model pushes expected pin changes
    always @(posedge clk) begin
        int nowc;
        nowc = cyc + 1;
        if (!rst_n) begin
            m_on = 0; m_sel = 0; m_pv = 0; m_prev = '0;
        end else if (!m_on) begin
            if (vid_load) begin
                m_on = 1; m_sel = 0; m_act = vid_in;
                m_end = nowc + eff_len(hold_len);
                push_exp(1'b0, m_act[2:0], nowc, "R7/R2");
            end
        end else if (nowc == m_end) begin
            if (!m_sel) begin
                if (vid_load) begin m_pend = vid_in; m_pv = 1; end
                m_sel = 1;
                push_exp(1'b1, m_act[5:3], nowc, "R3/R4/R5");
            end else begin
                if (vid_load)  m_act = vid_in;
                else if (m_pv) m_act = m_pend;
                m_pv = 0; m_sel = 0;
                push_exp(1'b0, m_act[2:0], nowc, "R2/R4/R5/R8");
            end
            m_end = nowc + eff_len(hold_len);
        end else if (vid_load) begin
            m_pend = vid_in; m_pv = 1;
        end
    end

    // monitor: compare observed changes with the queue
    logic [3:0] obs_prev = '0;
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            obs_prev <= '0;
        end else begin
            if ({vid_sel, vid_bus} != obs_prev) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected change R5/R8 cyc=%0d actual sel=%0b bus=%0d expected no change",
                             cyc, vid_sel, vid_bus);
                end else begin
                    e = q.pop_front();
                    if (e.s !== vid_sel || e.b !== vid_bus || e.c != cyc) begin
                        n_fail++;
                        $display("FAIL %s actual sel=%0b bus=%0d cyc=%0d expected sel=%0b bus=%0d cyc=%0d",
                                 e.req, vid_sel, vid_bus, cyc, e.s, e.b, e.c);
                    end
                end
            end
            obs_prev <= {vid_sel, vid_bus};
            if (q.size() > 0 && q[0].c < cyc) begin
                e = q.pop_front();
                n_chk++; n_fail++;
                $display("FAIL %s missing change actual none expected sel=%0b bus=%0d cyc=%0d",
                         e.req, e.s, e.b, e.c);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [5:0] code);
        @(negedge clk);
        vid_in = code; vid_load = 1'b1;
        @(negedge clk);
        vid_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: quiet pins with no load, even as other inputs move
        cur_req = "R1";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            vid_in = 6'(i * 11);
            hold_len = 16'(i + 1);
            n_chk++;
            if (vid_sel !== 1'b0 || vid_bus !== 3'd0) begin
                n_fail++;
                $display("FAIL R1 actual sel=%0b bus=%0d expected sel=0 bus=0", vid_sel, vid_bus);
            end
        end
        hold_len = 16'd4;

        cur_req = "R7";
        do_load(6'o52);
        wait_cyc(12);

        cur_req = "R8";
        do_load(6'o31);
        wait_cyc(20);

        cur_req = "R9";
        do_load(6'o17);
        do_load(6'o63);
        wait_cyc(20);

        // R9: load sampled on the edge that starts a low phase
        cur_req = "R9 edge";
        @(negedge clk);
        while (!(m_on && m_sel && m_end == cyc + 1)) @(negedge clk);
        vid_in = 6'o45; vid_load = 1'b1;
        @(negedge clk);
        vid_load = 1'b0;
        wait_cyc(20);

        cur_req = "R5 len7";
        wait_cyc(2);
        hold_len = 16'd7;
        wait_cyc(40);

        cur_req = "R5 len1";
        hold_len = 16'd1;
        do_load(6'o26);
        wait_cyc(12);

        cur_req = "R6";
        hold_len = 16'd0;
        do_load(6'o71);
        wait_cyc(3 * DEF_HOLD + 20);

        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R5 actual %0d pending expected 0 pending", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule